// File: doc/BRIEF.md
# Timer Count-Enable Selector and Gate

This block produces the single-cycle count-enable that advances a 16-bit timer channel running on one master clock. It takes five internal divided clock enables and three external clock lines, picks one of them as the counting source, can count on the falling transition of that source instead of the rising one, and can qualify it with a burst-gating line taken from one of the external lines.

Two control latches stand between the chosen source and the counter. The enable latch is set and cleared by software commands and can also be cleared by a mode-selected event from the counter logic. The run latch is set by any trigger and cleared by a mode-selected stop event, and it only reacts while the enable latch is set. A status output mirrors the enable latch. All command and event inputs are single-cycle pulses on the master clock.

Top module: `tc_clk_gate`

## Requirements
- R1: While `rst_ni` is low and after its release, both latches are clear: `clk_on_o` = 0 and `count_en_o` = 0 until an enable command and a trigger have both been seen.
- R2: `src_sel_i` codes 0 to 4 select `div_en_i[0]` to `div_en_i[4]` as a level used directly; codes 5, 6, 7 select `ext_clk_i[0]`, `[1]`, `[2]` after a two-flop synchronizer.
- R3: With `invert_i` = 0 a 0-to-1 transition of the selected level counts; with `invert_i` = 1 a 1-to-0 transition counts instead.
- R4: `burst_sel_i` = 0 applies no gating; values 1, 2, 3 allow counting only while synchronized `ext_clk_i[0]`, `[1]`, `[2]` respectively is high.
- R5: `cmd_enable_i` sets the enable latch unless `cmd_disable_i` is high in the same cycle, in which case the latch clears; `clk_on_o` equals the enable latch.
- R6: While the enable latch is clear, triggers and stop events leave the run latch unchanged; setting the enable latch again does not by itself start counting.
- R7: Any bit of `trig_i` sets the run latch when the enable latch is set; a stop event in the same cycle wins and the latch clears.
- R8: The stop event is `cmp_c_evt_i` when `wave_mode_i` = 1 and `load_b_evt_i` when `wave_mode_i` = 0, and acts only when `stop_on_evt_i` = 1.
- R9: The disable event is chosen the same way by `wave_mode_i` and acts only when `dis_on_evt_i` = 1; it clears the enable latch like `cmd_disable_i`.
- R10: `count_en_o` is registered: it is high for one cycle after each master edge at which the selected transition is seen, the gate is open and both latches are set. An external-line transition driven before edge k reaches `count_en_o` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_en_i | input | 5 | Internal divided clock enables, already synchronous |
| ext_clk_i | input | 3 | External clock lines, asynchronous |
| src_sel_i | input | 3 | Source select code |
| invert_i | input | 1 | Count on falling transition when 1 |
| burst_sel_i | input | 2 | Burst gating line select |
| wave_mode_i | input | 1 | Picks the compare event (1) or capture-load event (0) as stop/disable source |
| stop_on_evt_i | input | 1 | Mode event stops the run latch |
| dis_on_evt_i | input | 1 | Mode event clears the enable latch |
| load_b_evt_i | input | 1 | Second capture-load event pulse |
| cmp_c_evt_i | input | 1 | Period compare match event pulse |
| cmd_enable_i | input | 1 | Software enable command pulse |
| cmd_disable_i | input | 1 | Software disable command pulse |
| trig_i | input | 4 | Trigger pulses: software, sync, external, compare |
| clk_on_o | output | 1 | Enable latch status |
| count_en_o | output | 1 | Single-cycle count enable to the counter |

## Verification
The assertions assume command, trigger and event inputs are one-cycle pulses synchronous to the master clock and that external lines hold each level for more than one master period, so the synchronizer never drops a transition. The stimulus drives all synchronous inputs on the falling clock edge and toggles external lines with half-periods of several cycles. Select, invert and burst settings are changed only between measurement windows, so any transition caused by reselection falls outside the windows that are checked against fixed expectations.

// File: rtl/tc_clk_pkg.sv
package tc_clk_pkg;
  localparam int unsigned NUM_DIV     = 5;
  localparam int unsigned NUM_EXT     = 3;
  localparam int unsigned NUM_TRIG    = 4;
  localparam int unsigned SEL_W       = 3;
  localparam int unsigned BURST_W     = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/tc_clk_sync.sv
module tc_clk_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tc_clk_src.sv
module tc_clk_src #(
  parameter int unsigned NUM_DIV = 5,
  parameter int unsigned NUM_EXT = 3,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DIV-1:0] div_en_i,
  input  logic [NUM_EXT-1:0] ext_sync_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic               invert_i,
  input  logic [BURST_W-1:0] burst_sel_i,
  output logic               hit_o
);
  localparam int unsigned NSRC  = NUM_DIV + NUM_EXT;
  localparam int unsigned NCODE = 2 ** SEL_W;
  localparam int unsigned NGATE = 2 ** BURST_W;

  logic [NCODE-1:0] src_vec;
  logic [NGATE-1:0] gate_vec;
  logic             lvl, prev_q, edge_seen, gate_open;

  always_comb begin
    src_vec             = '0;
    src_vec[NSRC-1:0]   = {ext_sync_i, div_en_i};
    gate_vec            = '1;
    gate_vec[NUM_EXT:1] = ext_sync_i;
  end

  assign lvl       = src_vec[src_sel_i];
  assign gate_open = gate_vec[burst_sel_i];
  assign edge_seen = invert_i ? (prev_q & ~lvl) : (lvl & ~prev_q);
  assign hit_o     = edge_seen & gate_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  // R4: a closed burst line blocks every hit
  assert_gate_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_sel_i != '0 && !ext_sync_i[burst_sel_i - 1'b1]) |-> !hit_o);

  // R3: a falling-edge hit needs the level high on the previous edge
  assert_invert_falling_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invert_i && hit_o) |-> (!lvl && prev_q));
endmodule

// File: rtl/tc_clk_latch.sv
module tc_clk_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_en_i,
  input  logic cmd_dis_i,
  input  logic dis_evt_i,
  input  logic stop_evt_i,
  input  logic trig_i,
  output logic en_o,
  output logic run_o
);
  logic en_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (cmd_dis_i || dis_evt_i) en_q <= 1'b0;
      else if (cmd_en_i)          en_q <= 1'b1;
      if (en_q) begin
        if (stop_evt_i)  run_q <= 1'b0;
        else if (trig_i) run_q <= 1'b1;
      end
    end
  end

  assign en_o  = en_q;
  assign run_o = run_q;

  assert_dis_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i && cmd_dis_i) |=> !en_q);
  assert_en_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_i && !cmd_dis_i && !dis_evt_i) |=> en_q);
  assert_off_holds_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(run_q));
  assert_trig_starts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && trig_i && !stop_evt_i) |=> run_q);
  assert_stop_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && stop_evt_i) |=> !run_q);
  assert_dis_evt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_evt_i |=> !en_q);
endmodule

// File: rtl/tc_clk_gate.sv
module tc_clk_gate
  import tc_clk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_DIV-1:0]  div_en_i,
  input  logic [NUM_EXT-1:0]  ext_clk_i,
  input  logic [SEL_W-1:0]    src_sel_i,
  input  logic                invert_i,
  input  logic [BURST_W-1:0]  burst_sel_i,
  input  logic                wave_mode_i,
  input  logic                stop_on_evt_i,
  input  logic                dis_on_evt_i,
  input  logic                load_b_evt_i,
  input  logic                cmp_c_evt_i,
  input  logic                cmd_enable_i,
  input  logic                cmd_disable_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  output logic                clk_on_o,
  output logic                count_en_o
);
  logic [NUM_EXT-1:0] ext_sync;
  logic               hit, en, run, mode_evt, cnt_q;

  tc_clk_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (ext_clk_i), .q_o (ext_sync)
  );

  tc_clk_src #(.NUM_DIV(NUM_DIV), .NUM_EXT(NUM_EXT), .SEL_W(SEL_W), .BURST_W(BURST_W)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_en_i    (div_en_i),
    .ext_sync_i  (ext_sync),
    .src_sel_i   (src_sel_i),
    .invert_i    (invert_i),
    .burst_sel_i (burst_sel_i),
    .hit_o       (hit)
  );

  assign mode_evt = wave_mode_i ? cmp_c_evt_i : load_b_evt_i;

  tc_clk_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_en_i   (cmd_enable_i),
    .cmd_dis_i  (cmd_disable_i),
    .dis_evt_i  (dis_on_evt_i & mode_evt),
    .stop_evt_i (stop_on_evt_i & mode_evt),
    .trig_i     (|trig_i),
    .en_o       (en),
    .run_o      (run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 1'b0;
    else         cnt_q <= hit & en & run;
  end

  assign count_en_o = cnt_q;
  assign clk_on_o   = en;

  assert_pulse_needs_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en_o |-> $past(en && run));
  assert_off_no_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en || !run) |=> !count_en_o);
endmodule

// File: tb/tc_clk_gate_tb_top.sv
module tc_clk_gate_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] div_en = '0;
  logic [2:0] ext_clk = '0;
  logic [2:0] src_sel = '0;
  logic invert = 0, wave_mode = 0, stop_on = 0, dis_on = 0;
  logic [1:0] burst_sel = '0;
  logic load_b = 0, cmp_c = 0, cmd_en = 0, cmd_dis = 0;
  logic [3:0] trig = '0;
  logic clk_on, count_en;

  int checks = 0, errors = 0, cyc = 0;
  int ext_half [3] = '{0, 0, 0};
  int dut_pulses = 0, mdl_pulses = 0;
  bit done = 0;

  // reference model state
  bit m_en, m_run, m_prev, m_cnt;
  bit [2:0] h1, h2;

  always #5 clk = ~clk;

  tc_clk_gate dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .div_en_i (div_en), .ext_clk_i (ext_clk),
    .src_sel_i (src_sel), .invert_i (invert), .burst_sel_i (burst_sel),
    .wave_mode_i (wave_mode), .stop_on_evt_i (stop_on), .dis_on_evt_i (dis_on),
    .load_b_evt_i (load_b), .cmp_c_evt_i (cmp_c), .cmd_enable_i (cmd_en),
    .cmd_disable_i (cmd_dis), .trig_i (trig), .clk_on_o (clk_on), .count_en_o (count_en)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_run = 0; m_prev = 0; m_cnt = 0; h1 = '0; h2 = '0;
    end else begin
      bit lvl, gate, edge_ok, stop_e, mode_e;
      lvl  = (src_sel < 5) ? div_en[src_sel] : h2[src_sel - 5];
      gate = (burst_sel == 0) ? 1'b1 : h2[burst_sel - 1];
      edge_ok = invert ? (m_prev && !lvl) : (lvl && !m_prev);
      m_cnt  = edge_ok && gate && m_en && m_run;
      m_prev = lvl;
      mode_e = wave_mode ? cmp_c : load_b;
      stop_e = stop_on && mode_e;
      if (m_en) begin
        if (stop_e) m_run = 0;
        else if (trig != 0) m_run = 1;
      end
      if (cmd_dis || (dis_on && mode_e)) m_en = 0;
      else if (cmd_en) m_en = 1;
      h2 = h1; h1 = ext_clk;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison and stimulus generators
  always @(negedge clk) begin
    if (rst_ni) begin
      check(count_en == m_cnt, "R10 count_en vs model", count_en, m_cnt);
      check(clk_on == m_en, "R5 clk_on vs model", clk_on, m_en);
      dut_pulses += count_en;
      mdl_pulses += m_cnt;
    end
    cyc++;
    for (int i = 0; i < 5; i++) div_en[i] <= ((cyc % (2 * (i + 1))) == 0);
    for (int j = 0; j < 3; j++)
      if (ext_half[j] != 0 && (cyc % ext_half[j]) == 0) ext_clk[j] <= ~ext_clk[j];
  end

  task automatic window(int n);
    dut_pulses = 0; mdl_pulses = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(clk_on == 0 && count_en == 0, "R1 in reset", {clk_on, count_en}, 0);
    rst_ni = 1;
    @(negedge clk);
    check(clk_on == 0 && count_en == 0, "R1 after reset", {clk_on, count_en}, 0);

    // enable without trigger: no counting
    cmd_en = 1; @(negedge clk); cmd_en = 0;
    window(20);
    check(dut_pulses == 0, "R7 no count before trigger", dut_pulses, 0);
    check(clk_on == 1, "R5 enable sets status", clk_on, 1);

    trig[0] = 1; @(negedge clk); trig = '0;
    window(40);
    check(dut_pulses == mdl_pulses && dut_pulses > 0, "R2 div0 source", dut_pulses, mdl_pulses);

    src_sel = 2; settle(); window(60);
    check(dut_pulses == mdl_pulses && dut_pulses == 10, "R2 div2 source", dut_pulses, 10);
    invert = 1; settle(); window(60);
    check(dut_pulses == mdl_pulses && dut_pulses == 10, "R3 invert internal", dut_pulses, 10);

    invert = 0; ext_half[0] = 5; src_sel = 5; settle(); window(100);
    check(dut_pulses == mdl_pulses && dut_pulses == 10, "R2 ext0 source", dut_pulses, 10);
    invert = 1; settle(); window(100);
    check(dut_pulses == mdl_pulses && dut_pulses == 10, "R3 invert external", dut_pulses, 10);

    invert = 0; src_sel = 0; burst_sel = 2; ext_clk[1] = 0; settle(); window(40);
    check(dut_pulses == 0, "R4 burst line low blocks", dut_pulses, 0);
    ext_clk[1] = 1; settle(); window(40);
    check(dut_pulses == mdl_pulses && dut_pulses == 20, "R4 burst line high passes", dut_pulses, 20);
    burst_sel = 0;

    cmd_en = 1; cmd_dis = 1; @(negedge clk); cmd_en = 0; cmd_dis = 0;
    check(clk_on == 0, "R5 disable wins", clk_on, 0);
    cmd_en = 1; @(negedge clk); cmd_en = 0;
    check(clk_on == 1, "R5 re-enable", clk_on, 1);

    wave_mode = 1; stop_on = 1;
    load_b = 1; @(negedge clk); load_b = 0;
    window(20);
    check(dut_pulses == 10, "R8 load event ignored in wave mode", dut_pulses, 10);
    cmp_c = 1; @(negedge clk); cmp_c = 0;
    settle(); window(20);
    check(dut_pulses == 0, "R8 compare stops", dut_pulses, 0);
    trig[3] = 1; @(negedge clk); trig = '0;
    window(20);
    check(dut_pulses == mdl_pulses && dut_pulses > 0, "R7 trigger restarts", dut_pulses, mdl_pulses);

    // stop, disable, trigger while off, re-enable: must stay stopped
    cmp_c = 1; @(negedge clk); cmp_c = 0;
    cmd_dis = 1; @(negedge clk); cmd_dis = 0;
    trig[1] = 1; @(negedge clk); trig = '0;
    cmd_en = 1; @(negedge clk); cmd_en = 0;
    settle(); window(20);
    check(dut_pulses == 0, "R6 trigger ignored while disabled", dut_pulses, 0);

    trig[2] = 1; cmp_c = 1; @(negedge clk); trig = '0; cmp_c = 0;
    settle(); window(20);
    check(dut_pulses == 0, "R7 stop beats trigger", dut_pulses, 0);

    // disable event in capture mode
    wave_mode = 0; stop_on = 0; dis_on = 1;
    trig[0] = 1; @(negedge clk); trig = '0;
    cmp_c = 1; @(negedge clk); cmp_c = 0;
    check(clk_on == 1, "R9 compare ignored in capture mode", clk_on, 1);
    load_b = 1; @(negedge clk); load_b = 0;
    check(clk_on == 0, "R9 load event disables", clk_on, 0);
    settle(); window(20);
    check(dut_pulses == 0, "R9 no count after disable", dut_pulses, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule